// File: doc/BRIEF.md
# Far-End Alarm Channel Codeword Transmitter

This block drives the transmit side of a far-end alarm and control channel. The framer supplies one strobe per channel bit opportunity. On each strobe the block puts the next bit of a 16-bit codeword on its serial output. The host latches one or two 6-bit code values and a repetition mode with a single start pulse. The block then frames each code into a full codeword and counts how many times it has been sent. When the sequence is complete, the block falls back to a steady all-ones pattern and reports that it is idle.

The control path is a four-state machine. **IDLE** waits for start. **ARMED** holds the latched request until the next strobe. **FIRST** sends the first code. **SECOND** sends the second code, and is used only by the pair mode. The transitions are named as follows:
- `accept`: IDLE to ARMED, when start is high.
- `launch`: ARMED to FIRST, on a strobe.
- `repeat`: FIRST to FIRST or SECOND to SECOND, at the end of a codeword.
- `handover`: FIRST to SECOND, after ten codewords in pair mode.
- `finish`: FIRST or SECOND to IDLE, at the end of the last codeword.

Top module: `feac_tx`

## Requirements
- R1: After reset, `tx_idle` is 1 and `feac_bit` is 1.
- R2: Each codeword carries code value `c` and is sent lowest position first. Positions 0 to 7 are 1. Position 8 is 0. Positions 9 to 14 carry `c[0]` to `c[5]`. Position 15 is 0.
- R3: When `mode` is 2'b00, the block sends the first code 10 times and then goes idle. The value 2'b11 behaves the same way.
- R4: When `mode` is 2'b01, the first code repeats while `keep_on` is 1. Once `keep_on` is 0, the block goes idle at the end of the current codeword, but never before 10 codewords have been sent.
- R5: When `mode` is 2'b10, the block sends 10 codewords of `code_first` and then, with no gap, 10 codewords of `code_second`, and then goes idle.
- R6: The output advances by exactly one bit per cycle with `bit_stb` high. Without a strobe, `feac_bit` and `tx_idle` hold.
- R7: A start pulse received while a transmission is armed or running is ignored. It changes neither the code, the mode nor the length of the transmission.
- R8: A start pulse is accepted on any clock edge while the block is idle, and `tx_idle` stays 1 until the next strobe. On that strobe `tx_idle` falls to 0 and position 0 of the first codeword appears.
- R9: While idle, `feac_bit` is 1. `tx_idle` returns to 1 on the strobe that follows position 15 of the last codeword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb | input | 1 | Channel bit opportunity strobe |
| start | input | 1 | Start request, latched only while idle |
| mode | input | 2 | Repetition mode: 00 ten, 01 continuous, 10 pair, 11 ten |
| code_first | input | 6 | First (or only) code value |
| code_second | input | 6 | Second code value, used in pair mode |
| keep_on | input | 1 | Keeps continuous mode running while 1 |
| feac_bit | output | 1 | Serial channel bit |
| tx_idle | output | 1 | 1 while no codeword is being sent |

## Verification
Three things can land on the same strobe at the end of a codeword: advancing the bit position, counting the repetition, and deciding whether to hand over, repeat or finish. A wrong decision at that point therefore shows up as a stream of the wrong length or as a wrong code after the tenth word.

The bench provokes this in several ways:
- It sends pair-mode streams and compares every bit against the codeword expected for that repetition number.
- It clears `keep_on` before the tenth word, inside a later word, and exactly on a codeword boundary, and compares the stream length with the rule in R4.
- It sends a start pulse in the middle of a transmission, which must neither lengthen it nor change its code.

// File: rtl/feac_tx_pkg.sv
package feac_tx_pkg;

    localparam int CW_BITS   = 16;
    localparam int CODE_BITS = 6;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_FIRST  = 2'd2,
        ST_SECOND = 2'd3
    } tx_state_t;

    typedef enum logic [1:0] {
        MODE_TEN  = 2'd0,
        MODE_CONT = 2'd1,
        MODE_PAIR = 2'd2,
        MODE_RSVD = 2'd3
    } tx_mode_t;

endpackage

// File: rtl/feac_word_builder.sv
module feac_word_builder #(
    parameter int CODE_BITS = 6,
    parameter int CW_BITS   = 16
) (
    input  logic [CODE_BITS-1:0] code,
    output logic [CW_BITS-1:0]   word
);
    localparam int ONES = CW_BITS - CODE_BITS - 2;

    // Layout, lowest position first: ONES ones, a zero, the code bits, a closing zero.
    always_comb begin
        word = '0;
        for (int i = 0; i < ONES; i++) begin
            word[i] = 1'b1;
        end
        word[ONES] = 1'b0;
        for (int i = 0; i < CODE_BITS; i++) begin
            word[ONES + 1 + i] = code[i];
        end
        word[CW_BITS-1] = 1'b0;
    end
endmodule

// File: rtl/feac_rep_counter.sv
module feac_rep_counter #(
    parameter int REPS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = (REPS > 1) ? $clog2(REPS) : 1;
    localparam logic [CW-1:0] TOP = CW'(REPS - 1);

    logic [CW-1:0] cnt_q;

    // Saturating count of completed codewords.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != TOP)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == TOP);
endmodule

// File: rtl/feac_tx.sv
module feac_tx
    import feac_tx_pkg::*;
#(
    parameter int REPS = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_stb,
    input  logic                 start,
    input  logic [1:0]           mode,
    input  logic [CODE_BITS-1:0] code_first,
    input  logic [CODE_BITS-1:0] code_second,
    input  logic                 keep_on,
    output logic                 feac_bit,
    output logic                 tx_idle
);
    localparam int PW = $clog2(CW_BITS);
    localparam logic [PW-1:0] POS_LAST = PW'(CW_BITS - 1);

    tx_state_t state_q, state_d;
    tx_mode_t  mode_q;
    logic [CODE_BITS-1:0] code_a_q, code_b_q;
    logic [PW-1:0]        pos_q;
    logic [CW_BITS-1:0]   word_a, word_b, word_cur;
    logic                 rep_clr, rep_inc, rep_last;
    logic                 sending, word_end;

    feac_word_builder #(.CODE_BITS(CODE_BITS), .CW_BITS(CW_BITS)) u_word_a (
        .code (code_a_q),
        .word (word_a)
    );

    feac_word_builder #(.CODE_BITS(CODE_BITS), .CW_BITS(CW_BITS)) u_word_b (
        .code (code_b_q),
        .word (word_b)
    );

    feac_rep_counter #(.REPS(REPS)) u_reps (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rep_clr),
        .inc   (rep_inc),
        .last  (rep_last)
    );

    assign sending  = (state_q == ST_FIRST) || (state_q == ST_SECOND);
    assign word_end = sending && bit_stb && (pos_q == POS_LAST);

    // Next state: accept, launch, repeat, handover, finish.
    always_comb begin
        state_d = state_q;
        rep_clr = 1'b0;
        rep_inc = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_ARMED;                  // accept
            end
            ST_ARMED: begin
                if (bit_stb) begin
                    state_d = ST_FIRST;                         // launch
                    rep_clr = 1'b1;
                end
            end
            ST_FIRST: begin
                if (word_end) begin
                    rep_inc = 1'b1;
                    if (rep_last) begin
                        unique case (mode_q)
                            MODE_PAIR: begin
                                state_d = ST_SECOND;            // handover
                                rep_clr = 1'b1;
                            end
                            MODE_CONT: state_d = keep_on ? ST_FIRST : ST_IDLE;
                            default:   state_d = ST_IDLE;       // finish
                        endcase
                    end
                end
            end
            ST_SECOND: begin
                if (word_end) begin
                    rep_inc = 1'b1;
                    if (rep_last) state_d = ST_IDLE;            // finish
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with request latch and bit position.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            mode_q   <= MODE_TEN;
            code_a_q <= '0;
            code_b_q <= '0;
            pos_q    <= '0;
        end else begin
            state_q <= state_d;
            if ((state_q == ST_IDLE) && start) begin
                mode_q   <= tx_mode_t'(mode);
                code_a_q <= code_first;
                code_b_q <= code_second;
            end
            if (state_q == ST_ARMED) begin
                pos_q <= '0;
            end else if (sending && bit_stb) begin
                pos_q <= (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
            end
        end
    end

    // Outputs.
    always_comb begin
        word_cur = (state_q == ST_SECOND) ? word_b : word_a;
        feac_bit = sending ? word_cur[pos_q] : 1'b1;
        tx_idle  = !sending;
    end
endmodule

// File: rtl/feac_tx_checker.sv
module feac_tx_checker #(
    parameter int REPS    = 10,
    parameter int CW_BITS = 16
) (
    input logic clk,
    input logic rst_n,
    input logic bit_stb,
    input logic start,
    input logic feac_bit,
    input logic tx_idle
);
    localparam int MINB = REPS * CW_BITS;
    localparam int RW   = $clog2(MINB + 1);
    localparam int PW   = $clog2(CW_BITS);
    localparam int ONES = CW_BITS - 8;

    logic [RW-1:0] run_cnt;
    logic [PW-1:0] pos;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
            pos     <= '0;
        end else if (tx_idle) begin
            run_cnt <= '0;
            pos     <= '0;
        end else if (bit_stb) begin
            if (run_cnt != RW'(MINB)) run_cnt <= run_cnt + 1'b1;
            pos <= (pos == PW'(CW_BITS - 1)) ? '0 : pos + 1'b1;
        end
    end

    AST_HOLD_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_stb |=> $stable(feac_bit) && $stable(tx_idle)); // R6
    AST_IDLE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> feac_bit); // R9
    AST_FALL_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_idle) |-> $past(bit_stb) && feac_bit); // R8
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_idle && start && !bit_stb |=> !tx_idle); // R7
    AST_LEAD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_idle && (int'(pos) < ONES) |-> feac_bit); // R2
    AST_ZERO_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_idle && ((int'(pos) == ONES) || (int'(pos) == CW_BITS - 1)) |-> !feac_bit); // R2
    AST_MIN_REPEATS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_idle) |-> (int'($past(run_cnt)) >= MINB - 1)); // R4
endmodule

bind feac_tx feac_tx_checker #(.REPS(REPS), .CW_BITS(feac_tx_pkg::CW_BITS)) u_feac_tx_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_stb  (bit_stb),
    .start    (start),
    .feac_bit (feac_bit),
    .tx_idle  (tx_idle)
);

// File: tb/test_feac_tx.sv
`timescale 1ns/1ps
module test_feac_tx;

    typedef struct packed {
        logic [1:0]  md;
        logic [5:0]  ca;
        logic [5:0]  cb;
        logic [1:0]  per;
        logic [9:0]  stop;
        logic        poke;
        logic [9:0]  nbits;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 6'h2A, 6'h00, 2'd1, 10'd0,   1'b0, 10'd160},  // R3
        '{2'd0, 6'h15, 6'h00, 2'd3, 10'd0,   1'b1, 10'd160},  // R3 R7 R6
        '{2'd2, 6'h07, 6'h38, 2'd1, 10'd0,   1'b0, 10'd320},  // R5
        '{2'd1, 6'h3F, 6'h00, 2'd2, 10'd40,  1'b0, 10'd160},  // R4 early stop
        '{2'd1, 6'h01, 6'h00, 2'd1, 10'd200, 1'b0, 10'd208},  // R4 mid-word stop
        '{2'd1, 6'h00, 6'h00, 2'd1, 10'd176, 1'b0, 10'd176},  // R4 boundary stop
        '{2'd3, 6'h33, 6'h0C, 2'd1, 10'd0,   1'b0, 10'd160},  // R3 reserved
        '{2'd2, 6'h00, 6'h3F, 2'd2, 10'd0,   1'b0, 10'd320}   // R5
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_stb = 1'b0;
    logic start = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [5:0] code_first = '0;
    logic [5:0] code_second = '0;
    logic keep_on = 1'b0;
    logic feac_bit, tx_idle;

    int checks = 0;
    int errors = 0;
    int hold_bad = 0;

    always #4 clk = ~clk;

    feac_tx i_feac_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_stb     (bit_stb),
        .start       (start),
        .mode        (mode),
        .code_first  (code_first),
        .code_second (code_second),
        .keep_on     (keep_on),
        .feac_bit    (feac_bit),
        .tx_idle     (tx_idle)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic exp_bit(input logic [5:0] c, input int p);
        if (p < 8) return 1'b1;
        if (p == 8 || p == 15) return 1'b0;
        return c[p - 9];
    endfunction

    // One strobe, then gap cycles; outputs sampled after each edge.
    task automatic strobe(input int per);
        logic b, i;
        @(negedge clk) bit_stb = 1'b1;
        @(negedge clk) bit_stb = 1'b0;
        b = feac_bit;
        i = tx_idle;
        for (int g = 1; g < per; g++) begin
            @(negedge clk);
            if (feac_bit !== b || tx_idle !== i) hold_bad++;
        end
    endtask

    task automatic run_vec(input vec_t v);
        int n = 0;
        int bad = 0;
        bit done = 0;
        @(negedge clk);
        start = 1'b1; mode = v.md; code_first = v.ca; code_second = v.cb; keep_on = 1'b1;
        @(negedge clk) start = 1'b0;
        @(negedge clk);
        check("R8 idle held until strobe", int'(tx_idle), 1);
        while (!done && n < 1000) begin
            strobe(int'(v.per));
            if (tx_idle) begin
                done = 1;
            end else begin
                logic [5:0] c;
                c = (v.md == 2'd2 && (n / 16) >= 10) ? v.cb : v.ca;
                if (feac_bit !== exp_bit(c, n % 16)) bad++;
                n++;
                if (n == 1) check("R8 first bit after launch", int'(feac_bit), 1);
                if (v.stop != 0 && n == int'(v.stop)) keep_on = 1'b0;
                if (v.poke && n == 20) begin
                    @(negedge clk) start = 1'b1; mode = 2'd1; code_first = ~v.ca;
                    @(negedge clk) start = 1'b0;
                end
            end
        end
        check("R2 bit mismatches", bad, 0);
        if (v.md == 2'd1) check("R4 stream length", n, int'(v.nbits));
        else if (v.md == 2'd2) check("R5 stream length", n, int'(v.nbits));
        else if (v.poke) check("R7 length after busy start", n, int'(v.nbits));
        else check("R3 stream length", n, int'(v.nbits));
        check("R9 idle after end", int'(tx_idle && feac_bit), 1);
        keep_on = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 idle at reset", int'(tx_idle), 1);
        check("R1 bit at reset", int'(feac_bit), 1);
        rst_n = 1'b1;
        // Strobes without start keep the channel at ones.
        for (int k = 0; k < 5; k++) strobe(1);
        check("R9 ones with no start", int'(tx_idle && feac_bit), 1);

        for (int k = 0; k < NV; k++) run_vec(VEC[k]);
        check("R6 hold between strobes", hold_bad, 0);

        // Reset in the middle of a transmission.
        @(negedge clk) start = 1'b1; mode = 2'd0; code_first = 6'h3F;
        @(negedge clk) start = 1'b0;
        for (int k = 0; k < 12; k++) strobe(1);
        check("R6 busy before reset", int'(tx_idle), 0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 idle after reset", int'(tx_idle && feac_bit), 1);
        rst_n = 1'b1;

        // The next transmission starts cleanly from position 0.
        run_vec(VEC[0]);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule